// File: doc/BRIEF.md
# Block-Transfer DMA Channel

One DMA channel that copies data in blocks. Before use it is loaded with a source and a destination address (24 bits each), a unit count per block, a number of blocks, a unit size (byte or 16-bit word), a counting direction for each address, and a choice of which address rewinds. Each transfer request then moves one whole block. A block is a run of read-then-write unit copies over a simple bus master interface. That interface uses a valid/ready handshake on each read and on each write.

When a block ends, the rewinding address goes back to the value it was loaded with, and the other address keeps counting on from where it stopped. The channel counts how many blocks are left. It raises a sticky interrupt when the last block ends, and requests that arrive after that are ignored. A request that arrives while a block is running is remembered as one pending request. Clearing the enable input parks the channel at the next unit boundary, and setting it again resumes the unfinished block.

Top module: `blk_dma_channel`

## Requirements
- R1: After reset, rd_valid, wr_valid, irq and busy are all 0.
- R2: One accepted request causes exactly unit_count read/write unit pairs, after which busy returns to 0 without any further bus access.
- R3: Each write goes to the current destination address and carries the data returned by the read of the current source address just before it. Every access carries the loaded unit size on rd_word/wr_word (1 = word).
- R4: After each unit, an address steps by 1 for bytes or by 2 for words. It steps down when its direction input (src_down/dst_down) was 1 at load, and up otherwise.
- R5: At the end of every block, the destination address returns to its loaded value if rewind_dst was 1 at load, and the source address returns to its loaded value otherwise. The other address continues from where it stopped.
- R6: Each block decrements the block counter. Once block_count blocks are done, further requests cause no bus activity until the next load.
- R7: irq goes to 1 in the cycle after the write acceptance that ends the last block. It stays at 1 until irq_clr is pulsed. A set in the same cycle wins over a clear.
- R8: Any number of requests arriving during a block leave exactly one pending request, which starts one further block once the current one ends.
- R9: With enable at 0, the channel stops after the unit in progress completes and makes no more accesses. Setting enable back to 1 resumes the remaining units of that block without a new request.
- R10: Once raised, rd_valid holds with a stable rd_addr until rd_ready. Once raised, wr_valid holds with a stable wr_addr and wr_data until wr_ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| load | input | 1 | Take the configuration inputs (only while idle) |
| src_start | input | 24 | Source start address |
| dst_start | input | 24 | Destination start address |
| unit_count | input | 16 | Units per block |
| block_count | input | 16 | Number of blocks |
| word_mode | input | 1 | 1 = word units, 0 = byte units |
| rewind_dst | input | 1 | 1 = destination rewinds, 0 = source rewinds |
| src_down | input | 1 | Source counts downward |
| dst_down | input | 1 | Destination counts downward |
| enable | input | 1 | Channel run enable |
| req | input | 1 | Transfer request pulse |
| irq_clr | input | 1 | Clears irq |
| rd_valid | output | 1 | Read request valid |
| rd_addr | output | 24 | Read address |
| rd_word | output | 1 | Read unit size |
| rd_ready | input | 1 | Read accepted, data present |
| rd_data | input | 16 | Read data |
| wr_valid | output | 1 | Write request valid |
| wr_addr | output | 24 | Write address |
| wr_data | output | 16 | Write data |
| wr_word | output | 1 | Write unit size |
| wr_ready | input | 1 | Write accepted |
| irq | output | 1 | Completion interrupt |
| busy | output | 1 | Block in progress |

## Verification
A request sampled while idle raises rd_valid one cycle later. A read accepted at an edge raises wr_valid one cycle after that. A write accepted at an edge is followed one cycle later by either the next read or, at the end of a block, the return to idle together with any irq set. The monitor checks each access at the moment it is accepted, when valid and ready are both high just before the edge. It compares that access against the next entry queued by the driver, so stalls caused by the bench's ready patterns never move a comparison. The checks that expect nothing to happen (after the last block, and with enable at 0) first wait for busy to fall and then watch the bus for a fixed window.

// File: rtl/blk_dma_channel.sv
module blk_dma_channel #(
  parameter int AW = 24,
  parameter int DW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] src_start,
  input  logic [AW-1:0] dst_start,
  input  logic [CW-1:0] unit_count,
  input  logic [CW-1:0] block_count,
  input  logic          word_mode,
  input  logic          rewind_dst,
  input  logic          src_down,
  input  logic          dst_down,
  input  logic          enable,
  input  logic          req,
  input  logic          irq_clr,
  output logic          rd_valid,
  output logic [AW-1:0] rd_addr,
  output logic          rd_word,
  input  logic          rd_ready,
  input  logic [DW-1:0] rd_data,
  output logic          wr_valid,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          wr_word,
  input  logic          wr_ready,
  output logic          irq,
  output logic          busy
);

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR} st_t;

  st_t           st;
  logic [AW-1:0] src, dst, src0, dst0;
  logic [CW-1:0] size_q, units_left, blocks_left;
  logic [DW-1:0] data_q;
  logic          word_q, rew_dst_q, src_dn_q, dst_dn_q, pend;

  wire [AW-1:0] step    = word_q ? AW'(2) : AW'(1);
  wire [AW-1:0] src_nxt = src_dn_q ? src - step : src + step;
  wire [AW-1:0] dst_nxt = dst_dn_q ? dst - step : dst + step;
  wire          idle    = (st == S_IDLE);
  wire          start   = idle && !load && enable && units_left == '0 &&
                          (req || pend) && blocks_left != '0 && size_q != '0;
  wire          last_u  = (units_left == CW'(1));

  assign rd_valid = (st == S_RD);
  assign wr_valid = (st == S_WR);
  assign rd_addr  = src;
  assign wr_addr  = dst;
  assign wr_data  = data_q;
  assign rd_word  = word_q;
  assign wr_word  = word_q;
  assign busy     = !idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      src <= '0; dst <= '0; src0 <= '0; dst0 <= '0;
      size_q <= '0; units_left <= '0; blocks_left <= '0;
      data_q <= '0; word_q <= 1'b0; rew_dst_q <= 1'b0;
      src_dn_q <= 1'b0; dst_dn_q <= 1'b0; pend <= 1'b0; irq <= 1'b0;
    end else begin
      if (irq_clr) irq <= 1'b0;
      if (start)
        pend <= 1'b0;
      else if (req && blocks_left != '0)
        pend <= 1'b1;
      case (st)
        S_IDLE: begin
          if (load) begin
            src <= src_start; src0 <= src_start;
            dst <= dst_start; dst0 <= dst_start;
            size_q <= unit_count; blocks_left <= block_count;
            units_left <= '0; pend <= 1'b0;
            word_q <= word_mode; rew_dst_q <= rewind_dst;
            src_dn_q <= src_down; dst_dn_q <= dst_down;
          end else if (enable && units_left != '0) begin
            st <= S_RD;
          end else if (start) begin
            units_left <= size_q;
            st <= S_RD;
          end
        end
        S_RD: if (rd_ready) begin
          data_q <= rd_data;
          st <= S_WR;
        end
        S_WR: if (wr_ready) begin
          units_left <= units_left - CW'(1);
          if (last_u) begin
            src <= rew_dst_q ? src_nxt : src0;
            dst <= rew_dst_q ? dst0 : dst_nxt;
            blocks_left <= blocks_left - CW'(1);
            if (blocks_left == CW'(1)) irq <= 1'b1;
            st <= S_IDLE;
          end else begin
            src <= src_nxt;
            dst <= dst_nxt;
            st <= enable ? S_RD : S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr));

  assert_wr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

  assert_irq_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !irq_clr |=> irq);

  assert_irq_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> blocks_left == '0 && idle);

  assert_wr_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_valid) |-> wr_data == $past(rd_data));

  assert_one_block_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_ready && last_u |=> !busy);

endmodule

// File: tb/blk_dma_channel_tb.sv
module blk_dma_channel_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 24;
  localparam int DW = 16;
  localparam int CW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic load = 0, word_mode = 0, rewind_dst = 0, src_down = 0, dst_down = 0;
  logic enable = 1, req = 0, irq_clr = 0;
  logic [AW-1:0] src_start = '0, dst_start = '0;
  logic [CW-1:0] unit_count = '0, block_count = '0;
  logic rd_valid, rd_word, rd_ready = 0, wr_valid, wr_word, wr_ready = 0, irq, busy;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [DW-1:0] rd_data, wr_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [DW-1:0] memval(logic [AW-1:0] a);
    return {a[7:0], a[15:8]} ^ 16'h5A3C;
  endfunction
  assign rd_data = memval(rd_addr);

  blk_dma_channel #(.AW(AW), .DW(DW), .CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .load(load), .src_start(src_start), .dst_start(dst_start),
    .unit_count(unit_count), .block_count(block_count), .word_mode(word_mode),
    .rewind_dst(rewind_dst), .src_down(src_down), .dst_down(dst_down), .enable(enable),
    .req(req), .irq_clr(irq_clr), .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_word(rd_word),
    .rd_ready(rd_ready), .rd_data(rd_data), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_word(wr_word), .wr_ready(wr_ready), .irq(irq), .busy(busy));

  int n_tests = 0, n_fail = 0, writes_seen = 0;
  logic [AW+DW:0] exp_q[$];

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_tb();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  // bench model of the channel configuration and address state
  logic [AW-1:0] m_src, m_dst, m_src0, m_dst0;
  int m_size;
  bit m_word, m_rdst, m_sdn, m_ddn;

  task automatic do_load(input logic [AW-1:0] s, input logic [AW-1:0] d, input int size,
                         input int cnt, input bit w, input bit rd, input bit sd, input bit dd);
    @(negedge clk);
    src_start = s; dst_start = d; unit_count = CW'(size); block_count = CW'(cnt);
    word_mode = w; rewind_dst = rd; src_down = sd; dst_down = dd; load = 1;
    @(negedge clk);
    load = 0;
    m_src = s; m_dst = d; m_src0 = s; m_dst0 = d; m_size = size;
    m_word = w; m_rdst = rd; m_sdn = sd; m_ddn = dd;
  endtask

  task automatic push_block();
    logic [AW-1:0] st;
    st = m_word ? AW'(2) : AW'(1);
    for (int i = 0; i < m_size; i++) begin
      exp_q.push_back({m_word, m_dst, memval(m_src)});
      m_src = m_sdn ? m_src - st : m_src + st;
      m_dst = m_ddn ? m_dst - st : m_dst + st;
    end
    if (m_rdst) m_dst = m_dst0; else m_src = m_src0;
  endtask

  task automatic pulse_req();
    @(negedge clk); req = 1;
    @(negedge clk); req = 0;
  endtask

  task automatic wait_done(input string tag);
    int t = 0;
    @(negedge clk);
    while ((exp_q.size() != 0 || busy) && t < 5000) begin
      @(negedge clk); t++;
    end
    check(exp_q.size() == 0 && !busy, tag, exp_q.size(), 0);
  endtask

  // ready pattern and scoreboard monitor
  logic [7:0] lfsr = 8'hB5;
  bit rd_stall = 0, wr_stall = 0;
  logic [AW-1:0] rd_hold_a, wr_hold_a;
  logic [DW-1:0] wr_hold_d;
  always @(negedge clk) begin
    if (rst_n) begin
      if (rd_stall)
        check(rd_valid && rd_addr == rd_hold_a, "R10 read hold", {rd_valid, rd_addr}, {1'b1, rd_hold_a});
      if (wr_stall)
        check(wr_valid && wr_addr == wr_hold_a && wr_data == wr_hold_d, "R10 write hold",
              {wr_valid, wr_addr}, {1'b1, wr_hold_a});
    end
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    rd_ready = lfsr[0] | lfsr[1];
    wr_ready = lfsr[2] | lfsr[4];
    rd_stall = rst_n && rd_valid && !rd_ready;
    wr_stall = rst_n && wr_valid && !wr_ready;
    rd_hold_a = rd_addr; wr_hold_a = wr_addr; wr_hold_d = wr_data;
    if (rst_n && rd_valid && rd_ready)
      check(rd_word == m_word, "R3 read size", rd_word, m_word);
    if (rst_n && wr_valid && wr_ready) begin
      writes_seen++;
      if (exp_q.size() == 0)
        check(0, "R2 R6 unexpected write", wr_addr, 0);
      else begin
        logic [AW+DW:0] e, a;
        e = exp_q.pop_front();
        a = {wr_word, wr_addr, wr_data};
        check(a == e, "R3 R4 R5 write item", a, e);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    finish_tb();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(!rd_valid && !wr_valid && !irq && !busy, "R1 reset state",
          {rd_valid, wr_valid, irq, busy}, 0);

    // bytes, both up, source rewinds: 2 blocks of 3
    do_load(24'h000100, 24'h800000, 3, 2, 0, 0, 0, 0);
    push_block(); pulse_req(); wait_done("R2 block one");
    check(irq == 0, "R7 irq low mid-run", irq, 0);
    push_block(); pulse_req(); wait_done("R2 block two");
    @(negedge clk);
    check(irq == 1, "R7 irq set", irq, 1);
    repeat (5) @(negedge clk);
    check(irq == 1, "R7 irq held", irq, 1);
    irq_clr = 1; @(negedge clk); irq_clr = 0;
    check(irq == 0, "R7 irq cleared", irq, 0);

    // count exhausted: request ignored
    begin
      bit act = 0;
      pulse_req();
      for (int i = 0; i < 15; i++) begin
        @(negedge clk);
        if (rd_valid || busy) act = 1;
      end
      check(!act && irq == 0, "R6 request after last block", act, 0);
    end

    // words, dst down and rewinds, src up: 3 blocks of 4, pending requests
    do_load(24'h00F000, 24'h123456, 4, 3, 1, 1, 0, 1);
    push_block(); push_block();
    pulse_req();
    pulse_req(); pulse_req();
    wait_done("R8 two blocks");
    repeat (12) @(negedge clk);
    check(!busy && exp_q.size() == 0 && irq == 0, "R8 single pending", {busy, irq}, 0);
    push_block(); pulse_req(); wait_done("R5 third block");
    @(negedge clk);
    check(irq == 1, "R7 irq after three", irq, 1);
    irq_clr = 1; @(negedge clk); irq_clr = 0;

    // halt and resume: bytes, src down, dst rewinds, 1 block of 5
    do_load(24'h000050, 24'h000A00, 5, 1, 0, 1, 1, 0);
    push_block();
    begin
      int base, snap, t;
      base = writes_seen; t = 0;
      pulse_req();
      while (writes_seen < base + 2 && t < 2000) begin @(negedge clk); t++; end
      enable = 0;
      t = 0;
      @(negedge clk);
      while (busy && t < 2000) begin @(negedge clk); t++; end
      snap = writes_seen;
      repeat (20) @(negedge clk);
      check(writes_seen == snap && !busy && exp_q.size() > 0, "R9 halted",
            writes_seen, snap);
      check(irq == 0, "R9 no irq while halted", irq, 0);
      enable = 1;
      wait_done("R9 resumed");
      @(negedge clk);
      check(irq == 1, "R9 R7 irq after resume", irq, 1);
    end
    finish_tb();
  end
endmodule